// File: doc/BRIEF.md
# Time Alarm Comparator with Wildcard

This block stores the alarm values for seconds, minutes, hours, date and month. After each finished time update, it compares the running time against those values. The running time is counted elsewhere and arrives as five byte inputs. A single-cycle update-done strobe marks the moment when the time bytes are fresh. In that cycle the block checks all five fields. If every field agrees, it latches an alarm flag.

Alarm bytes use the same encoding as the time bytes they are compared with. That covers BCD or binary values and 12- or 24-hour hours, with the PM marker in bit 7. The comparison is a plain 8-bit equality, so the PM marker must also agree.

An alarm byte whose two top bits are both 1 is a wildcard and agrees with any time value. The flag stays set until the host reads the status, which the host signals with a read strobe. The interrupt output is the flag, gated by the alarm enable and by the clock-running input.

Top module: `alarm_match`

## Requirements
- R1: After reset, every alarm byte is 0x00, and both the flag and the interrupt are low.
- R2: A write with `wr_en` high loads `wr_data` into the alarm byte chosen by `wr_sel`. The encoding is 0 seconds, 1 minutes, 2 hours, 3 date, 4 month. Select values 5 to 7 change no alarm byte.
- R3: When `upd_done` is high at a clock edge and all five fields agree, `alarm_flag` is high from that edge onward.
- R4: Without an `upd_done` strobe, the flag never sets, even if every field agrees.
- R5: An alarm byte with bits 7 and 6 both 1 agrees with any time value. A byte with only bit 7 set is compared normally.
- R6: A single field that disagrees prevents the flag from setting. In the hours field, the comparison includes bit 7, the PM marker.
- R7: A set flag holds until a cycle with `stat_rd` high, which clears it at that edge. If a match and `stat_rd` happen in the same cycle, the flag stays set.
- R8: The flag sets whatever the value of `alarm_ie`. `alarm_irq` is high exactly when the flag is set, `alarm_ie` is 1 and `rtc_on` is 1.
- R9: While `rtc_on` is 0, `alarm_irq` stays low, even when the flag is set and `alarm_ie` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for an alarm byte |
| wr_sel | input | 3 | Alarm byte index (0 sec, 1 min, 2 hour, 3 date, 4 month) |
| wr_data | input | 8 | Alarm byte value |
| upd_done | input | 1 | One-cycle strobe: time update finished |
| cur_sec | input | 8 | Current seconds |
| cur_min | input | 8 | Current minutes |
| cur_hour | input | 8 | Current hours, PM marker in bit 7 in 12-hour mode |
| cur_date | input | 8 | Current date of month |
| cur_month | input | 8 | Current month |
| alarm_ie | input | 1 | Alarm interrupt enable |
| rtc_on | input | 1 | Clock running; low forces the interrupt off |
| stat_rd | input | 1 | Host status read strobe; clears the flag |
| alarm_flag | output | 1 | Latched alarm match |
| alarm_irq | output | 1 | Gated alarm interrupt |

## Verification
The bench builds the block with its defaults: 8-bit fields and five compared fields. That puts every field's wildcard and mismatch paths within reach, including the PM marker in bit 7 of the hours byte. The 3-bit select also reaches the three unused codes 5 to 7, so the bench can show that writes to them are ignored. The flag-set versus status-read race and the gating by enable and clock-running are driven directly, cycle by cycle.

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int DW = 8,
  parameter int NF = 5,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          upd_done,
  input  logic [DW-1:0] cur_sec,
  input  logic [DW-1:0] cur_min,
  input  logic [DW-1:0] cur_hour,
  input  logic [DW-1:0] cur_date,
  input  logic [DW-1:0] cur_month,
  input  logic          alarm_ie,
  input  logic          rtc_on,
  input  logic          stat_rd,
  output logic          alarm_flag,
  output logic          alarm_irq
);

  logic [NF-1:0][DW-1:0] al_q;
  logic [NF-1:0][DW-1:0] now_t;
  logic [NF-1:0]         fld_ok;
  logic                  hit;

  assign now_t = {cur_month, cur_date, cur_hour, cur_min, cur_sec};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NF; i++)
        if (wr_sel == SW'(i)) al_q[i] <= wr_data;
    end
  end

  for (genvar g = 0; g < NF; g++) begin : g_fld
    assign fld_ok[g] = (&al_q[g][DW-1:DW-2]) || (al_q[g] == now_t[g]);
  end

  assign hit = &fld_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)                alarm_flag <= 1'b0;
    else if (upd_done && hit)  alarm_flag <= 1'b1;
    else if (stat_rd)          alarm_flag <= 1'b0;
  end

  assign alarm_irq = alarm_flag & alarm_ie & rtc_on;

  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && hit) |=> alarm_flag); // R3
  AST_SET_NEEDS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(upd_done)); // R4
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !stat_rd) |=> alarm_flag); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !upd_done) |=> !alarm_flag); // R7
  AST_IRQ_OFF_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rtc_on || !alarm_flag) |-> !alarm_irq); // R9

endmodule

// File: tb/alarm_match_tb.sv
module alarm_match_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, upd_done = 0, alarm_ie = 0, rtc_on = 0, stat_rd = 0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0, c_sec = '0, c_min = '0, c_hour = '0, c_date = '0, c_mon = '0;
  logic flag, irq;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  alarm_match u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd_done(upd_done), .cur_sec(c_sec), .cur_min(c_min), .cur_hour(c_hour),
    .cur_date(c_date), .cur_month(c_mon), .alarm_ie(alarm_ie), .rtc_on(rtc_on),
    .stat_rd(stat_rd), .alarm_flag(flag), .alarm_irq(irq));

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic upd();
    @(negedge clk); upd_done = 1;
    @(negedge clk); upd_done = 0;
  endtask

  task automatic rd();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, d, mo);
    @(negedge clk); c_sec = s; c_min = m; c_hour = h; c_date = d; c_mon = mo;
  endtask

  task automatic prog_all(input logic [7:0] s, m, h, d, mo);
    wr(0, s); wr(1, m); wr(2, h); wr(3, d); wr(4, mo);
  endtask

  task automatic t_reset();
    chk("R1 flag", flag, 0); chk("R1 irq", irq, 0);
    rtc_on = 1; alarm_ie = 1;
    upd();
    chk("R1 zero alarms match zero time", flag, 1);
    rd();
    chk("R7 read clears", flag, 0);
  endtask

  task automatic t_match();
    set_time(8'h30, 8'h45, 8'h92, 8'h15, 8'h07);
    prog_all(8'h30, 8'h45, 8'h92, 8'h15, 8'h07);
    repeat (3) @(negedge clk);
    chk("R4 no strobe no flag", flag, 0);
    upd();
    chk("R3 flag on match", flag, 1);
    chk("R8 irq", irq, 1);
    repeat (4) @(negedge clk);
    chk("R7 flag holds", flag, 1);
    rd();
    chk("R7 read clears", flag, 0);
  endtask

  task automatic t_mismatch();
    wr(2, 8'h12);
    upd();
    chk("R6 PM bit disagrees", flag, 0);
    wr(2, 8'h92); wr(1, 8'h46);
    upd();
    chk("R6 minutes disagree", flag, 0);
    wr(1, 8'h45); wr(4, 8'h08);
    upd();
    chk("R6 month disagrees", flag, 0);
    wr(4, 8'h07); wr(0, 8'h31);
    upd();
    chk("R2 seconds write took effect", flag, 0);
    wr(0, 8'h30);
  endtask

  task automatic t_wild();
    wr(2, 8'h80);
    upd();
    chk("R5 only bit7 is not wildcard", flag, 0);
    prog_all(8'hC0, 8'hFF, 8'hC3, 8'hC0, 8'hE1);
    set_time(8'h05, 8'h3B, 8'h17, 8'h1F, 8'h0C);
    upd();
    chk("R5 all wildcards", flag, 1);
    rd();
    wr(2, 8'h17);
    upd();
    chk("R5 wildcard plus exact hour", flag, 1);
    rd();
  endtask

  task automatic t_ignored();
    set_time(8'h30, 8'h45, 8'h92, 8'h15, 8'h07);
    prog_all(8'h30, 8'h45, 8'h92, 8'h15, 8'h07);
    wr(5, 8'h00); wr(6, 8'h01); wr(7, 8'h02);
    upd();
    chk("R2 selects 5-7 ignored", flag, 1);
    rd();
  endtask

  task automatic t_gate();
    alarm_ie = 0;
    upd();
    chk("R8 flag sets with enable off", flag, 1);
    chk("R8 irq gated by enable", irq, 0);
    alarm_ie = 1; #1;
    chk("R8 irq follows enable", irq, 1);
    rtc_on = 0; #1;
    chk("R9 irq off while stopped", irq, 0);
    chk("R9 flag kept", flag, 1);
    rtc_on = 1; #1;
    chk("R8 irq back", irq, 1);
  endtask

  task automatic t_race();
    @(negedge clk); upd_done = 1; stat_rd = 1;
    @(negedge clk); upd_done = 0; stat_rd = 0;
    chk("R7 set wins over read", flag, 1);
    rd();
    chk("R7 cleared", flag, 0);
    chk("R8 irq low after clear", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_match();
    t_mismatch();
    t_wild();
    t_ignored();
    t_gate();
    t_race();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule